// File: doc/BRIEF.md
# Self-Starting Three-Winding Stepper Phase Sequencer

This block steps a three-winding stepper motor through a six-phase half-step pattern. The machine's state is the winding pattern. Each of the three output bits switches one winding: 1 energizes it and 0 leaves it off. The machine advances one phase per clock while the step enable is high. It holds its phase while the step enable is low.

The block uses three flip-flops, so two of the eight codes are not part of the cycle. These are the all-off code and the all-on code. A power-up value, an upset or a bad preset can leave the register in one of them. In either case the machine returns to the home phase, winding A alone, on the very next clock. This happens whatever the step enable is doing. A synchronous preset path can place any code, legal or not, into the phase register. It is used to start from a chosen phase, and it is the only way to reach the unused codes from the pins.

The states, written as {A,B,C}, are:
- PH_A = 100
- PH_AB = 110
- PH_B = 010
- PH_BC = 011
- PH_C = 001
- PH_CA = 101
- PH_OFF = 000 (unused)
- PH_ALL = 111 (unused)

The transitions are:
- STEP: moves each legal state to the next one in the cycle PH_A → PH_AB → PH_B → PH_BC → PH_C → PH_CA → PH_A.
- HOLD: keeps a legal state when the step enable is low.
- RECOVER: moves PH_OFF or PH_ALL to PH_A.
- PRESET: loads the preset code.
- HOME: loads PH_A on reset.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase becomes PH_A, and the outputs read coil_a=1, coil_b=0, coil_c=0 after that edge.
- R2: With `step_en` high and no reset or preset, each clock moves a legal phase one place along the cycle. In {A,B,C} form the cycle is 100 → 110 → 010 → 011 → 001 → 101 → 100.
- R3: With `step_en` low and no reset or preset, a legal phase is held unchanged on every clock.
- R4: Code 000 (PH_OFF) becomes 100 on the next clock, whether `step_en` is high or low.
- R5: Code 111 (PH_ALL) becomes 100 on the next clock, whether `step_en` is high or low.
- R6: When `preset_en` is high and `rst` is low, the next clock loads `preset_code` into the phase, with bit 2 = A, bit 1 = B and bit 0 = C. The preset takes priority over `step_en`.
- R7: Reset takes priority over preset: with both high, the phase becomes 100.
- R8: The outputs follow the phase register with no added delay. In every legal phase exactly one or two windings are energized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to PH_A, active high |
| step_en | input | 1 | Advance one phase per clock when high |
| preset_en | input | 1 | Synchronous load of `preset_code` |
| preset_code | input | 3 | Code to load, {A,B,C} |
| coil_a | output | 1 | Winding A drive, 1 = energized |
| coil_b | output | 1 | Winding B drive, 1 = energized |
| coil_c | output | 1 | Winding C drive, 1 = energized |

## Verification
The hardest situation to reach is an unused code, because normal stepping never produces one. The stimulus forces the phase to 000 or 111 through the preset path. It then releases the preset with the step enable high in one trial and low in another. It confirms that PH_A appears after exactly one clock. Preset priority is also tested: the bench asserts preset together with step enable, and then together with reset, and checks which source wins.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
    localparam int COIL_COUNT = 3;
    localparam int CYCLE_LEN  = 6;

    typedef enum logic [COIL_COUNT-1:0] {
        PH_OFF = 3'b000,
        PH_C   = 3'b001,
        PH_B   = 3'b010,
        PH_BC  = 3'b011,
        PH_A   = 3'b100,
        PH_CA  = 3'b101,
        PH_AB  = 3'b110,
        PH_ALL = 3'b111
    } phase_e;

    localparam phase_e HOME_PHASE = PH_A;

    function automatic logic is_legal(input logic [COIL_COUNT-1:0] code);
        return (code != PH_OFF) && (code != PH_ALL);
    endfunction
endpackage

// File: rtl/stepper_next_logic.sv
module stepper_next_logic
    import stepper_pkg::*;
(
    input  phase_e cur_phase,
    input  logic   step_en,
    output phase_e nxt_phase
);
    always_comb begin
        unique case (cur_phase)
            PH_A:    nxt_phase = step_en ? PH_AB : PH_A;
            PH_AB:   nxt_phase = step_en ? PH_B  : PH_AB;
            PH_B:    nxt_phase = step_en ? PH_BC : PH_B;
            PH_BC:   nxt_phase = step_en ? PH_C  : PH_BC;
            PH_C:    nxt_phase = step_en ? PH_CA : PH_C;
            PH_CA:   nxt_phase = step_en ? PH_A  : PH_CA;
            PH_OFF:  nxt_phase = HOME_PHASE;   // recover
            PH_ALL:  nxt_phase = HOME_PHASE;   // recover
            default: nxt_phase = HOME_PHASE;
        endcase
    end
endmodule

// File: rtl/stepper_state_reg.sv
module stepper_state_reg
    import stepper_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   preset_en,
    input  phase_e preset_phase,
    input  phase_e nxt_phase,
    output phase_e phase_q
);
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= HOME_PHASE;
        else if (preset_en)
            phase_q <= preset_phase;
        else
            phase_q <= nxt_phase;
    end

    AST_RESET_HOME: assert property (@(posedge clk)
        rst |=> phase_q == PH_A);                                   // R1
    AST_RESET_OVER_PRESET: assert property (@(posedge clk)
        (rst && preset_en) |=> phase_q == PH_A);                    // R7
    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (rst)
        preset_en |=> phase_q == $past(preset_phase));              // R6
endmodule

// File: rtl/stepper_coil_drive.sv
module stepper_coil_drive
    import stepper_pkg::*;
(
    input  phase_e phase_q,
    output logic   coil_a,
    output logic   coil_b,
    output logic   coil_c
);
    always_comb begin
        unique case (phase_q)
            PH_A:    {coil_a, coil_b, coil_c} = 3'b100;
            PH_AB:   {coil_a, coil_b, coil_c} = 3'b110;
            PH_B:    {coil_a, coil_b, coil_c} = 3'b010;
            PH_BC:   {coil_a, coil_b, coil_c} = 3'b011;
            PH_C:    {coil_a, coil_b, coil_c} = 3'b001;
            PH_CA:   {coil_a, coil_b, coil_c} = 3'b101;
            PH_OFF:  {coil_a, coil_b, coil_c} = 3'b000;
            PH_ALL:  {coil_a, coil_b, coil_c} = 3'b111;
            default: {coil_a, coil_b, coil_c} = 3'b000;
        endcase
    end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stepper_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_en,
    input  logic       preset_en,
    input  logic [2:0] preset_code,
    output logic       coil_a,
    output logic       coil_b,
    output logic       coil_c
);
    phase_e phase_q;
    phase_e nxt_phase;
    phase_e preset_phase;

    assign preset_phase = phase_e'(preset_code);

    stepper_next_logic u_next (
        .cur_phase (phase_q),
        .step_en   (step_en),
        .nxt_phase (nxt_phase)
    );

    stepper_state_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .preset_en    (preset_en),
        .preset_phase (preset_phase),
        .nxt_phase    (nxt_phase),
        .phase_q      (phase_q)
    );

    stepper_coil_drive u_drive (
        .phase_q (phase_q),
        .coil_a  (coil_a),
        .coil_b  (coil_b),
        .coil_c  (coil_c)
    );

    AST_ONE_COIL_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && step_en && is_legal(phase_q))
        |=> $countones(phase_q ^ $past(phase_q)) == 1);             // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && !step_en && is_legal(phase_q)) |=> $stable(phase_q)); // R3
    AST_OFF_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && phase_q == PH_OFF) |=> {coil_a, coil_b, coil_c} == 3'b100); // R4
    AST_ALL_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        (!preset_en && phase_q == PH_ALL) |=> {coil_a, coil_b, coil_c} == 3'b100); // R5
    AST_COIL_COUNT: assert property (@(posedge clk) disable iff (rst)
        !preset_en |=> ($countones({coil_a, coil_b, coil_c}) inside {1, 2})); // R8
endmodule

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       preset_en = 1'b0;
    logic [2:0] preset_code = 3'b000;
    logic       coil_a, coil_b, coil_c;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] model = 3'b100;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepper_phase_seq u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .preset_en(preset_en),
        .preset_code(preset_code), .coil_a(coil_a), .coil_b(coil_b), .coil_c(coil_c)
    );

    function automatic logic [2:0] cycle_after(input logic [2:0] c);
        case (c)
            3'b100: return 3'b110;
            3'b110: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b001;
            3'b001: return 3'b101;
            3'b101: return 3'b100;
            default: return 3'b100;
        endcase
    endfunction

    // Driver: one clock per call, pushes the value expected after that edge.
    task automatic drive(input logic r, input logic en, input logic pe,
                         input logic [2:0] code, input string tag);
        @(negedge clk);
        rst = r; step_en = en; preset_en = pe; preset_code = code;
        if (r)                                    model = 3'b100;
        else if (pe)                              model = code;
        else if (model == 3'b000 || model == 3'b111) model = 3'b100;
        else if (en)                              model = cycle_after(model);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                logic [2:0] got;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = {coil_a, coil_b, coil_c};
                total++;
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s: coils=%b expected=%b", t, got, e);
                end
                if (e != 3'b000 && e != 3'b111) begin
                    total++;
                    if (!($countones(got) inside {1, 2})) begin
                        bad++;
                        $display("FAIL R8: coils=%b expected one or two set", got);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(1, 0, 0, 3'b000, "R1 reset");
        drive(1, 1, 0, 3'b000, "R1 reset held");
        for (int i = 0; i < 12; i++) drive(0, 1, 0, 3'b000, "R2 step");
        for (int i = 0; i < 3; i++)  drive(0, 0, 0, 3'b000, "R3 hold");
        for (int i = 0; i < 8; i++)  drive(0, i[0], 0, 3'b000, "R2 R3 alternate");
        drive(0, 0, 1, 3'b000, "R6 preset 000");
        drive(0, 0, 0, 3'b000, "R4 recover idle");
        drive(0, 0, 1, 3'b000, "R6 preset 000");
        drive(0, 1, 0, 3'b000, "R4 recover stepping");
        drive(0, 1, 1, 3'b111, "R6 preset 111");
        drive(0, 1, 0, 3'b000, "R5 recover stepping");
        drive(0, 0, 1, 3'b111, "R6 preset 111");
        drive(0, 0, 0, 3'b000, "R5 recover idle");
        drive(0, 1, 1, 3'b011, "R6 preset over step");
        drive(0, 1, 0, 3'b000, "R2 step from preset");
        drive(0, 0, 1, 3'b101, "R6 preset idle");
        drive(0, 0, 0, 3'b000, "R3 hold after preset");
        drive(1, 1, 1, 3'b011, "R7 reset over preset");
        drive(1, 0, 1, 3'b111, "R7 reset over illegal preset");
        for (int i = 0; i < 6; i++) drive(0, 1, 0, 3'b000, "R2 cycle after reset");
        @(negedge clk);
        step_en = 0;
        while (exp_q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule